// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Pair

This block keeps the pending-event flags and the per-source enable mask of a peripheral register bank, and turns them into one interrupt request line. Event sources (a shift register and two timers) report with single-cycle set pulses. The host reaches the two registers through a simple register-select, write-strobe and read-data port. The host clears a pending event by writing a one to its flag bit. The enable register is changed by writing a value whose top bit picks the operation: set the marked bits or clear them.

Bit 7 reads differently from how it writes. On a flag read it summarises whether any enabled event is pending. On an enable read it is always one. On an enable write it selects set or clear. Only the shift-register and timer-1 sources can raise the request output. Timer 2 can be pending and enabled without interrupting, so software must poll for it.

Top module: `irq_flag_enable`

## Requirements
- R1: A pulse on `set_shift`, `set_tmr1` or `set_tmr2` sets flag bit 2, 6 or 5 respectively at the next clock edge. The flag register is selected by `reg_sel` = 4'h2.
- R2: A write to the flag register clears every flag bit whose `wr_data` bit is 1, and leaves bits written as 0 unchanged.
- R3: A flag read returns the flags in bits 6:0. Bit 7 is 1 exactly when some flag bit is also enabled, and this includes the timer-2 bit.
- R4: A write to the enable register (`reg_sel` = 4'h3) with `wr_data[7]` = 1 ORs `wr_data[6:0]` into the enable bits.
- R5: A write to the enable register with `wr_data[7]` = 0 clears every enable bit whose `wr_data` bit is 1.
- R6: An enable read always returns bit 7 as 1, with the enable bits in bits 6:0.
- R7: A pending and enabled timer-2 flag (bit 5) never drives `irq`. Only bits 2 and 6 can.
- R8: Reset clears both registers and `irq`.
- R9: When a set pulse and a write-one-to-clear target the same flag bit in the same cycle, the bit ends set.
- R10: `irq` is registered. It changes one clock edge after the flag or enable change that causes it.
- R11: Writes to any index other than 4'h2 and 4'h3 change nothing, and reads of such an index return 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 4 | Register index |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for the selected register |
| set_shift | input | 1 | Shift-register event pulse |
| set_tmr1 | input | 1 | Timer-1 event pulse |
| set_tmr2 | input | 1 | Timer-2 event pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
A corrupted flag or enable bit is visible on `rd_data` in the same cycle the register is selected after the faulty edge, in its own bit position or through the read summary in bit 7. The same fault shows on `irq` one edge later, provided it falls in bit 2 or 6. A wrong write rule (set versus clear, or the wrong polarity of the clear mask) shows on the read immediately after the write. A wrong request mask shows as `irq` rising two edges after a timer-2 pulse, while `irq` should stay low.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;

    localparam int SRC_W  = 7;
    localparam int DATA_W = SRC_W + 1;

    localparam int SR_BIT = 2;
    localparam int T2_BIT = 5;
    localparam int T1_BIT = 6;

    localparam logic [SRC_W-1:0] REQ_MASK =
        SRC_W'((1 << SR_BIT) | (1 << T1_BIT));

    typedef struct packed {
        logic [SRC_W-1:0] bits;
    } src_vec_t;

endpackage

// File: rtl/irqfe_flag_reg.sv
module irqfe_flag_reg
    import irqfe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] set_vec,
    input  logic             clr_we,
    input  logic [SRC_W-1:0] clr_vec,
    output logic [SRC_W-1:0] flag_q_o
);

    src_vec_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we) begin
            st_d.bits = st_d.bits & ~clr_vec;
        end
        // set pulses applied last so they win over a same-cycle clear
        st_d.bits = st_d.bits | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_q_o = st_q.bits;

endmodule

// File: rtl/irqfe_enable_reg.sv
module irqfe_enable_reg
    import irqfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [SRC_W-1:0]  ena_q_o
);

    src_vec_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (wdata[DATA_W-1]) begin
                st_d.bits = st_q.bits | wdata[SRC_W-1:0];
            end else begin
                st_d.bits = st_q.bits & ~wdata[SRC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ena_q_o = st_q.bits;

endmodule

// File: rtl/irqfe_req_gen.sv
module irqfe_req_gen
    import irqfe_pkg::*;
#(
    parameter logic [SRC_W-1:0] MASK = REQ_MASK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] flags,
    input  logic [SRC_W-1:0] enables,
    output logic             any_active_o,
    output logic             irq_q_o
);

    typedef struct packed {
        logic irq;
    } req_t;

    req_t st_d, st_q;
    logic [SRC_W-1:0] active;

    always_comb begin
        active       = flags & enables;
        any_active_o = |active;
        st_d.irq     = |(active & MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_q_o = st_q.irq;

endmodule

// File: rtl/irq_flag_enable.sv
module irq_flag_enable
    import irqfe_pkg::*;
#(
    parameter int              SEL_W    = 4,
    parameter logic [SEL_W-1:0] FLAG_SEL = 4'h2,
    parameter logic [SEL_W-1:0] ENA_SEL  = 4'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              set_shift,
    input  logic              set_tmr1,
    input  logic              set_tmr2,
    output logic              irq
);

    logic [SRC_W-1:0] set_vec;
    logic [SRC_W-1:0] flag_vec;
    logic [SRC_W-1:0] ena_vec;
    logic             flag_we;
    logic             ena_we;
    logic             any_active;

    for (genvar i = 0; i < SRC_W; i++) begin : g_set
        if (i == SR_BIT) begin : g_sr
            assign set_vec[i] = set_shift;
        end else if (i == T1_BIT) begin : g_t1
            assign set_vec[i] = set_tmr1;
        end else if (i == T2_BIT) begin : g_t2
            assign set_vec[i] = set_tmr2;
        end else begin : g_none
            assign set_vec[i] = 1'b0;
        end
    end

    always_comb begin
        flag_we = wr_en && (reg_sel == FLAG_SEL);
        ena_we  = wr_en && (reg_sel == ENA_SEL);
    end

    irqfe_flag_reg u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_we   (flag_we),
        .clr_vec  (wr_data[SRC_W-1:0]),
        .flag_q_o (flag_vec)
    );

    irqfe_enable_reg u_enables (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ena_we),
        .wdata   (wr_data),
        .ena_q_o (ena_vec)
    );

    irqfe_req_gen #(.MASK(REQ_MASK)) u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .flags        (flag_vec),
        .enables      (ena_vec),
        .any_active_o (any_active),
        .irq_q_o      (irq)
    );

    always_comb begin
        rd_data = '0;
        if (reg_sel == FLAG_SEL) begin
            rd_data = {any_active, flag_vec};
        end else if (reg_sel == ENA_SEL) begin
            rd_data = {1'b1, ena_vec};
        end
    end

endmodule

// File: rtl/irqfe_checker.sv
module irqfe_checker
    import irqfe_pkg::*;
#(
    parameter int              SEL_W    = 4,
    parameter logic [SEL_W-1:0] FLAG_SEL = 4'h2,
    parameter logic [SEL_W-1:0] ENA_SEL  = 4'h3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  reg_sel,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              set_shift,
    input logic              set_tmr1,
    input logic              set_tmr2,
    input logic              irq,
    input logic [SRC_W-1:0]  flag_vec,
    input logic [SRC_W-1:0]  ena_vec
);

    logic no_pulse;
    assign no_pulse = !set_shift && !set_tmr1 && !set_tmr2;

    assert_set_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        set_shift |=> flag_vec[SR_BIT]);

    assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == FLAG_SEL && no_pulse) |=>
        flag_vec == ($past(flag_vec) & ~$past(wr_data[SRC_W-1:0])));

    assert_flag_summary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == FLAG_SEL) |-> rd_data[DATA_W-1] == |(flag_vec & ena_vec));

    assert_ena_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == ENA_SEL && wr_data[DATA_W-1]) |=>
        ena_vec == ($past(ena_vec) | $past(wr_data[SRC_W-1:0])));

    assert_ena_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == ENA_SEL && !wr_data[DATA_W-1]) |=>
        ena_vec == ($past(ena_vec) & ~$past(wr_data[SRC_W-1:0])));

    assert_ena_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == ENA_SEL) |-> rd_data[DATA_W-1]);

    assert_no_tmr2_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_vec & ena_vec & REQ_MASK) == '0) |=> !irq);

    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_R8: assert (flag_vec == '0 && ena_vec == '0 && !irq);
        end
    end

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_tmr1 && wr_en && reg_sel == FLAG_SEL && wr_data[T1_BIT]) |=>
        flag_vec[T1_BIT]);

    assert_irq_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == |($past(flag_vec & ena_vec) & REQ_MASK));

    assert_other_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel != FLAG_SEL && reg_sel != ENA_SEL) |-> rd_data == '0);

endmodule

bind irq_flag_enable irqfe_checker #(
    .SEL_W    (SEL_W),
    .FLAG_SEL (FLAG_SEL),
    .ENA_SEL  (ENA_SEL)
) u_irqfe_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .set_shift (set_shift),
    .set_tmr1  (set_tmr1),
    .set_tmr2  (set_tmr2),
    .irq       (irq),
    .flag_vec  (flag_vec),
    .ena_vec   (ena_vec)
);

// File: tb/test_irq_flag_enable.sv
`timescale 1ns/1ps
module test_irq_flag_enable;

    localparam logic [3:0] FSEL = 4'h2;
    localparam logic [3:0] ESEL = 4'h3;
    localparam logic [3:0] XSEL = 4'h7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_sel = 4'h0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       set_shift = 1'b0;
    logic       set_tmr1 = 1'b0;
    logic       set_tmr2 = 1'b0;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    irq_flag_enable i_irq_flag_enable (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .set_shift (set_shift),
        .set_tmr1  (set_tmr1),
        .set_tmr2  (set_tmr2),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] sel, input logic [7:0] data);
        @(negedge clk);
        reg_sel = sel; wr_data = data; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic s, input logic t1, input logic t2);
        @(negedge clk);
        set_shift = s; set_tmr1 = t1; set_tmr2 = t2;
        @(negedge clk);
        set_shift = 1'b0; set_tmr1 = 1'b0; set_tmr2 = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] sel, input logic [7:0] exp);
        reg_sel = sel;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rd_check("R8 flags in reset", FSEL, 8'h00);
        check("R8 irq in reset", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        rd_check("R8 flags after reset", FSEL, 8'h00);
        rd_check("R6 enable read after reset", ESEL, 8'h80);
    endtask

    task automatic t_sources();
        pulse(1'b1, 1'b0, 1'b0);
        rd_check("R1 shift sets bit 2", FSEL, 8'h04);
        pulse(1'b0, 1'b0, 1'b1);
        rd_check("R1 tmr2 sets bit 5", FSEL, 8'h24);
        pulse(1'b0, 1'b1, 1'b0);
        rd_check("R3 tmr1 sets bit 6, nothing enabled", FSEL, 8'h64);
        check("R7 no irq with enables off", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_clear();
        wr(FSEL, 8'h20);
        rd_check("R2 clear bit 5 only", FSEL, 8'h44);
        wr(FSEL, 8'h00);
        rd_check("R2 zero write keeps flags", FSEL, 8'h44);
    endtask

    task automatic t_enable();
        wr(ESEL, 8'h84);
        rd_check("R4 set enable bit 2", ESEL, 8'h84);
        check("R10 irq not yet raised", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check("R10 irq raised one edge later", {7'd0, irq}, 8'h01);
        rd_check("R3 summary bit set", FSEL, 8'hC4);
        wr(ESEL, 8'hC0);
        rd_check("R4 OR adds bit 6", ESEL, 8'hC4);
        wr(ESEL, 8'h04);
        rd_check("R5 clear enable bit 2", ESEL, 8'hC0);
    endtask

    task automatic t_irq_drop();
        wr(FSEL, 8'h40);
        rd_check("R2 clear bit 6", FSEL, 8'h04);
        check("R10 irq still high", {7'd0, irq}, 8'h01);
        @(negedge clk);
        check("R10 irq low one edge later", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_tmr2();
        wr(FSEL, 8'h7F);
        wr(ESEL, 8'hA0);
        rd_check("R4 enable tmr2", ESEL, 8'hE0);
        pulse(1'b0, 1'b0, 1'b1);
        rd_check("R3 summary counts tmr2", FSEL, 8'hA0);
        @(negedge clk);
        @(negedge clk);
        check("R7 tmr2 gives no irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_set_wins();
        wr(FSEL, 8'h7F);
        @(negedge clk);
        reg_sel = FSEL; wr_data = 8'h40; wr_en = 1'b1; set_tmr1 = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; set_tmr1 = 1'b0;
        rd_check("R9 set beats clear", FSEL, 8'hC0);
        @(negedge clk);
        check("R9 irq from kept bit", {7'd0, irq}, 8'h01);
    endtask

    task automatic t_other_index();
        wr(XSEL, 8'hFF);
        rd_check("R11 flags untouched", FSEL, 8'hC0);
        wr(XSEL, 8'h7F);
        rd_check("R11 enables untouched", ESEL, 8'hE0);
        rd_check("R11 other index reads zero", XSEL, 8'h00);
        wr(ESEL, 8'h7F);
        rd_check("R6 bit 7 with all enables clear", ESEL, 8'h80);
        rd_check("R3 summary clear, flag kept", FSEL, 8'h40);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sources();
        t_clear();
        t_enable();
        t_irq_drop();
        t_tmr2();
        t_set_wins();
        t_other_index();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule